// File: doc/BRIEF.md
# Power-Domain Gating Sequencer

This block switches a small set of peripheral power domains on and off when software asks it to. Software talks to it through a 32-bit register window with simple read and write strobes. Each domain has three outputs: a power-switch enable, an isolation clamp and a reset hold. Some domains also have an active-low power-down handshake pin that software controls, plus an acknowledge input that the sequencer waits on.

To request a transition, software first sets the domain's bit in the mapping register. It then sets the domain's bit in the power-up or power-down request register. A single sequencer finds the lowest-numbered domain that is allowed to run and steps through a fixed, counted sequence. When the sequence is done, the sequencer clears the request bit itself, so software polls that bit to learn the transition has finished. A status register per domain reports whether the domain is off.

The sequencer has six states. The states are IDLE, UP_SWITCH, UP_RELEASE, DOWN_ISOLATE, DOWN_RESET and DOWN_WAIT. The transitions are:
- IDLE→UP_SWITCH when the picked domain has a power-up request.
- IDLE→DOWN_ISOLATE when the picked domain has only a power-down request.
- UP_SWITCH→UP_RELEASE after SETTLE_CYC cycles.
- UP_RELEASE→IDLE after STEP_CYC cycles. This is completion.
- DOWN_ISOLATE→DOWN_RESET after STEP_CYC cycles.
- DOWN_RESET→DOWN_WAIT after STEP_CYC cycles.
- DOWN_WAIT→IDLE as soon as the acknowledge condition holds. This is completion.

Top module: `pgc_ctrl`

## Requirements
- R1: After reset:
  - every register reads 0;
  - every switch enable is 0, and every isolation and reset output is 1;
  - every status bit reads 1 (off);
  - hsk_req_n is 0 for handshake domains and 1 for the others.
- R2: Register layout (bit d belongs to domain d):
  - mapping register at 0x0EC;
  - power-up request register at 0x0F8;
  - power-down request register at 0x104;
  - handshake register at 0x1FC, whose bit d drives hsk_req_n[d] for handshake domains;
  - for domain d, a control register at 0x800 + (16+d)*0x40, whose bit 0 is the power-down enable;
  - a status register 0xC above each control register, whose bit 0 is 1 while the domain is off;
  - any other address reads 0.
  A read returns data on bus_rdata one clock after the read strobe.
- R3: Writes to the request registers only set bits. A written 0 leaves a pending request bit at 1.
- R4: Power-up runs in this order:
  - close the switch with isolation and reset still held, for SETTLE_CYC cycles;
  - release reset, for STEP_CYC cycles;
  - remove isolation. At this same edge the request bit clears and the status reads 0.
- R5: Power-down runs in this order:
  - assert isolation, for STEP_CYC cycles;
  - assert reset, for STEP_CYC cycles;
  - open the switch. At this same edge the request bit clears and the status reads 1.
- R6: A request is not serviced while the domain's mapping bit is 0. It stays pending and the outputs do not change.
- R7: A power-down request is not serviced while the domain's control enable bit is 0.
- R8: When power-up and power-down are both pending for one domain, power-up runs and the power-down bit is cleared without any action.
- R9: On a handshake domain, the switch does not open until hsk_ack_n for that domain is low.
- R10: Only one sequence runs at a time, and the lowest-numbered eligible domain goes first.
- R11: Whenever a switch enable is 0, isolation and reset are both 1. Reset is never 1 while isolation is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| hsk_ack_n | input | N_DOM | Active-low power-down acknowledge, per domain |
| pwr_sw_on | output | N_DOM | Power switch enable, per domain |
| iso_on | output | N_DOM | Isolation clamp, per domain |
| rst_on | output | N_DOM | Reset hold, per domain |
| hsk_req_n | output | N_DOM | Active-low power-down request, per domain |

## Verification
The bench targets these corner cases, and each one has a visible failure mode:
- An unmapped domain with a request pending. A design that ignores the mapping bit would power that domain anyway.
- A request register written with zero. A plainly written register would lose the pending request.
- A power-down request with the enable bit cleared. A design that ignores the enable bit would power the domain down.
- A handshake domain with its acknowledge held high. A design that skips the acknowledge would open the switch early.
- Power-up and power-down pending together. Giving power-down priority would leave the domain off.
- Two domains pending at once. A wrong pick order would run the higher-numbered domain first.
- Phase lengths and output ordering are compared cycle by cycle against a model, so an off-by-one step count shows up at once.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UP_SWITCH,
        S_UP_RELEASE,
        S_DOWN_ISOLATE,
        S_DOWN_RESET,
        S_DOWN_WAIT
    } seq_state_e;

    localparam logic [11:0] ADDR_MAP   = 12'h0EC;
    localparam logic [11:0] ADDR_UPREQ = 12'h0F8;
    localparam logic [11:0] ADDR_DNREQ = 12'h104;
    localparam logic [11:0] ADDR_HSK   = 12'h1FC;
    localparam logic [11:0] ADDR_DOM0  = 12'h800;
    localparam int          DOM_STRIDE = 64;
    localparam logic [11:0] STATUS_OFS = 12'h00C;

endpackage

// File: rtl/pgc_regs.sv
module pgc_regs #(
    parameter int N_DOM    = 4,
    parameter int PGC_BASE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [N_DOM-1:0] clr_up,
    input  logic [N_DOM-1:0] clr_dn,
    input  logic [N_DOM-1:0] pwr,
    output logic [N_DOM-1:0] map_q,
    output logic [N_DOM-1:0] up_q,
    output logic [N_DOM-1:0] dn_q,
    output logic [N_DOM-1:0] en_q,
    output logic [N_DOM-1:0] hsk_q
);
    import pgc_pkg::*;

    localparam int PAD = 32 - N_DOM;

    function automatic logic [11:0] ctl_addr(input int d);
        return ADDR_DOM0 + 12'((PGC_BASE + d) * DOM_STRIDE);
    endfunction

    logic [N_DOM-1:0] wset;
    logic [31:0]      rd_val;

    assign wset = bus_wdata[N_DOM-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q     <= '0;
            up_q      <= '0;
            dn_q      <= '0;
            hsk_q     <= '0;
            bus_rdata <= '0;
        end else begin
            if (bus_wr && bus_addr == ADDR_MAP) map_q <= wset;
            if (bus_wr && bus_addr == ADDR_HSK) hsk_q <= wset;
            up_q <= (up_q & ~clr_up) | ((bus_wr && bus_addr == ADDR_UPREQ) ? wset : '0);
            dn_q <= (dn_q & ~clr_dn) | ((bus_wr && bus_addr == ADDR_DNREQ) ? wset : '0);
            if (bus_rd) bus_rdata <= rd_val;
        end
    end

    for (genvar g = 0; g < N_DOM; g++) begin : g_ctl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en_q[g] <= 1'b0;
            else if (bus_wr && bus_addr == ctl_addr(g))
                en_q[g] <= bus_wdata[0];
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (bus_addr)
            ADDR_MAP:   rd_val = {{PAD{1'b0}}, map_q};
            ADDR_UPREQ: rd_val = {{PAD{1'b0}}, up_q};
            ADDR_DNREQ: rd_val = {{PAD{1'b0}}, dn_q};
            ADDR_HSK:   rd_val = {{PAD{1'b0}}, hsk_q};
            default:    rd_val = '0;
        endcase
        for (int d = 0; d < N_DOM; d++) begin
            if (bus_addr == ctl_addr(d))              rd_val = {31'b0, en_q[d]};
            if (bus_addr == ctl_addr(d) + STATUS_OFS) rd_val = {31'b0, ~pwr[d]};
        end
    end

endmodule

// File: rtl/pgc_seq.sv
module pgc_seq #(
    parameter int               N_DOM      = 4,
    parameter int               SETTLE_CYC = 6,
    parameter int               STEP_CYC   = 3,
    parameter logic [N_DOM-1:0] HSK_MASK   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DOM-1:0] map_q,
    input  logic [N_DOM-1:0] up_q,
    input  logic [N_DOM-1:0] dn_q,
    input  logic [N_DOM-1:0] en_q,
    input  logic [N_DOM-1:0] hsk_ack_n,
    output logic [N_DOM-1:0] clr_up,
    output logic [N_DOM-1:0] clr_dn,
    output logic [N_DOM-1:0] pwr,
    output logic [N_DOM-1:0] sw_on,
    output logic [N_DOM-1:0] iso_on,
    output logic [N_DOM-1:0] rst_on
);
    import pgc_pkg::*;

    localparam int MAXC  = (SETTLE_CYC > STEP_CYC) ? SETTLE_CYC : STEP_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int DW    = (N_DOM > 1) ? $clog2(N_DOM) : 1;
    localparam logic [CNT_W-1:0] SETTLE_L = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] STEP_L   = CNT_W'(STEP_CYC - 1);

    seq_state_e       state, state_nx;
    logic [DW-1:0]    dom, pick;
    logic [CNT_W-1:0] cnt;
    logic [N_DOM-1:0] elig;
    logic             any, tdone, ack_ok;

    assign elig   = map_q & (up_q | (dn_q & en_q));
    assign any    = |elig;
    assign ack_ok = !HSK_MASK[dom] || !hsk_ack_n[dom];

    always_comb begin
        pick = '0;
        for (int i = N_DOM - 1; i >= 0; i--)
            if (elig[i]) pick = DW'(i);
    end

    always_comb begin
        tdone = 1'b0;
        unique case (state)
            S_UP_SWITCH:                   tdone = (cnt == SETTLE_L);
            S_UP_RELEASE, S_DOWN_ISOLATE,
            S_DOWN_RESET:                  tdone = (cnt == STEP_L);
            default:                       tdone = 1'b0;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:         if (any) state_nx = up_q[pick] ? S_UP_SWITCH : S_DOWN_ISOLATE;
            S_UP_SWITCH:    if (tdone) state_nx = S_UP_RELEASE;
            S_UP_RELEASE:   if (tdone) state_nx = S_IDLE;
            S_DOWN_ISOLATE: if (tdone) state_nx = S_DOWN_RESET;
            S_DOWN_RESET:   if (tdone) state_nx = S_DOWN_WAIT;
            S_DOWN_WAIT:    if (ack_ok) state_nx = S_IDLE;
            default:        state_nx = S_IDLE;
        endcase
    end

    // state register, step counter, selected domain and power record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            dom   <= '0;
            pwr   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state_nx != state) ? '0 : cnt + 1'b1;
            if (state == S_IDLE) dom <= pick;
            if (state == S_UP_RELEASE && tdone) pwr[dom] <= 1'b1;
            if (state == S_DOWN_WAIT && ack_ok) pwr[dom] <= 1'b0;
        end
    end

    // request clears and per-domain outputs
    always_comb begin
        clr_up = '0;
        clr_dn = '0;
        sw_on  = pwr;
        iso_on = ~pwr;
        rst_on = ~pwr;
        unique case (state)
            S_IDLE:         if (any && up_q[pick]) clr_dn[pick] = 1'b1;
            S_UP_SWITCH:    begin sw_on[dom] = 1'b1; iso_on[dom] = 1'b1; rst_on[dom] = 1'b1; end
            S_UP_RELEASE:   begin
                                sw_on[dom] = 1'b1; iso_on[dom] = 1'b1; rst_on[dom] = 1'b0;
                                clr_up[dom] = tdone;
                            end
            S_DOWN_ISOLATE: begin sw_on[dom] = 1'b1; iso_on[dom] = 1'b1; rst_on[dom] = 1'b0; end
            S_DOWN_RESET:   begin sw_on[dom] = 1'b1; iso_on[dom] = 1'b1; rst_on[dom] = 1'b1; end
            S_DOWN_WAIT:    begin
                                sw_on[dom] = 1'b1; iso_on[dom] = 1'b1; rst_on[dom] = 1'b1;
                                clr_dn[dom] = ack_ok;
                            end
            default:        ;
        endcase
    end

endmodule

// File: rtl/pgc_ctrl.sv
module pgc_ctrl #(
    parameter int               N_DOM      = 4,
    parameter int               PGC_BASE   = 16,
    parameter int               SETTLE_CYC = 6,
    parameter int               STEP_CYC   = 3,
    parameter logic [N_DOM-1:0] HSK_MASK   = 4'b0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [N_DOM-1:0] hsk_ack_n,
    output logic [N_DOM-1:0] pwr_sw_on,
    output logic [N_DOM-1:0] iso_on,
    output logic [N_DOM-1:0] rst_on,
    output logic [N_DOM-1:0] hsk_req_n
);
    logic [N_DOM-1:0] map_q, up_q, dn_q, en_q, hsk_q, clr_up, clr_dn, pwr;

    pgc_regs #(.N_DOM(N_DOM), .PGC_BASE(PGC_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clr_up(clr_up), .clr_dn(clr_dn), .pwr(pwr),
        .map_q(map_q), .up_q(up_q), .dn_q(dn_q), .en_q(en_q), .hsk_q(hsk_q)
    );

    pgc_seq #(.N_DOM(N_DOM), .SETTLE_CYC(SETTLE_CYC), .STEP_CYC(STEP_CYC),
              .HSK_MASK(HSK_MASK)) u_seq (
        .clk(clk), .rst_n(rst_n), .map_q(map_q), .up_q(up_q), .dn_q(dn_q),
        .en_q(en_q), .hsk_ack_n(hsk_ack_n), .clr_up(clr_up), .clr_dn(clr_dn),
        .pwr(pwr), .sw_on(pwr_sw_on), .iso_on(iso_on), .rst_on(rst_on)
    );

    assign hsk_req_n = hsk_q | ~HSK_MASK;

endmodule

// File: rtl/pgc_ctrl_chk.sv
module pgc_ctrl_chk #(
    parameter int               N_DOM    = 4,
    parameter logic [N_DOM-1:0] HSK_MASK = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DOM-1:0] sw_on,
    input logic [N_DOM-1:0] iso_on,
    input logic [N_DOM-1:0] rst_on,
    input logic [N_DOM-1:0] hsk_ack_n
);
    assert_off_is_clamped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (~sw_on & ~(iso_on & rst_on)) == '0);

    assert_reset_under_iso_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_on & ~iso_on) == '0);

    assert_one_switch_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sw_on ^ $past(sw_on)) <= 1);

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        assert_close_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sw_on[d]) |-> (iso_on[d] && rst_on[d]));
        if (HSK_MASK[d]) begin : g_hsk
            assert_wait_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (sw_on[d] && hsk_ack_n[d]) |=> sw_on[d]);
        end
    end
endmodule

bind pgc_ctrl pgc_ctrl_chk #(.N_DOM(N_DOM), .HSK_MASK(HSK_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_on(pwr_sw_on), .iso_on(iso_on),
    .rst_on(rst_on), .hsk_ack_n(hsk_ack_n)
);

// File: tb/sim_pgc_ctrl.sv
module sim_pgc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 4;
    localparam int SETTLE = 6;
    localparam int STEP   = 3;
    localparam logic [3:0] HSK = 4'b0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  hsk_ack_n = 4'hF;
    logic [3:0]  pwr_sw_on, iso_on, rst_on, hsk_req_n;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    pgc_ctrl u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural model: phase 0 idle, 1 settle, 2 release, 3 isolate, 4 reset, 5 wait-ack
    int m_ph = 0, m_left = 0, m_dom = 0;
    bit [3:0] m_map, m_up, m_dn, m_en, m_on, m_hsk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_dom = 0;
            m_map = 0; m_up = 0; m_dn = 0; m_en = 0; m_on = 0; m_hsk = 0;
        end else begin
            bit [3:0] cu, cd;
            cu = 0; cd = 0;
            case (m_ph)
                0: begin
                    for (int i = 3; i >= 0; i--)
                        if (m_map[i] && (m_up[i] || (m_dn[i] && m_en[i]))) m_dom = i;
                    if (m_map[m_dom] && (m_up[m_dom] || (m_dn[m_dom] && m_en[m_dom]))) begin
                        if (m_up[m_dom]) begin
                            cd[m_dom] = 1; m_ph = 1; m_left = SETTLE;
                        end else begin
                            m_ph = 3; m_left = STEP;
                        end
                    end
                end
                1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_left = STEP; end end
                2: begin m_left--; if (m_left == 0) begin m_on[m_dom] = 1; cu[m_dom] = 1; m_ph = 0; end end
                3: begin m_left--; if (m_left == 0) begin m_ph = 4; m_left = STEP; end end
                4: begin m_left--; if (m_left == 0) m_ph = 5; end
                default: if (!HSK[m_dom] || !hsk_ack_n[m_dom]) begin
                    m_on[m_dom] = 0; cd[m_dom] = 1; m_ph = 0;
                end
            endcase
            m_up = m_up & ~cu;
            m_dn = m_dn & ~cd;
            if (bus_wr) begin
                if (bus_addr == 12'h0EC) m_map = bus_wdata[3:0];
                if (bus_addr == 12'h0F8) m_up  = m_up | bus_wdata[3:0];
                if (bus_addr == 12'h104) m_dn  = m_dn | bus_wdata[3:0];
                if (bus_addr == 12'h1FC) m_hsk = bus_wdata[3:0];
                for (int d = 0; d < N; d++)
                    if (bus_addr == 12'(12'h800 + (16 + d) * 64)) m_en[d] = bus_wdata[0];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [3:0] esw, eiso, erst;
            for (int d = 0; d < N; d++) begin
                if (m_ph != 0 && d == m_dom) begin
                    esw[d] = 1; eiso[d] = 1; erst[d] = !(m_ph == 2 || m_ph == 3);
                end else begin
                    esw[d] = m_on[d]; eiso[d] = !m_on[d]; erst[d] = !m_on[d];
                end
            end
            chk({cur_req, " sw/iso/rst"}, {20'b0, esw, eiso, erst},
                {20'b0, pwr_sw_on, iso_on, rst_on});
            chk({cur_req, " hsk_req_n"}, {28'b0, hsk_req_n}, {28'b0, m_hsk | ~HSK});
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic poll_clear(input string tag, input logic [11:0] a, input int bitn);
        logic [31:0] v;
        for (int k = 0; k < 200; k++) begin
            rd(a, v);
            if (!v[bitn]) return;
        end
        chk({tag, " poll timeout"}, v, 32'h0);
    endtask

    function automatic logic [11:0] ctl(input int d);
        return 12'(12'h800 + (16 + d) * 64);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        chk("R1 switch", {28'b0, pwr_sw_on}, 32'h0);
        chk("R1 iso", {28'b0, iso_on}, 32'hF);
        chk("R1 reset", {28'b0, rst_on}, 32'hF);
        chk("R1 hsk pins", {28'b0, hsk_req_n}, 32'hB);
        rd_chk("R1 status d0", ctl(0) + 12'h00C, 32'h1);
        rd_chk("R1 up reg", 12'h0F8, 32'h0);
        rd_chk("R1 map reg", 12'h0EC, 32'h0);
        // R2: layout and readback
        cur_req = "R2";
        wr(12'h0EC, 32'h5);
        rd_chk("R2 map", 12'h0EC, 32'h5);
        wr(ctl(1), 32'h1);
        rd_chk("R2 ctrl d1", ctl(1), 32'h1);
        wr(12'h1FC, 32'h4);
        rd_chk("R2 hsk reg", 12'h1FC, 32'h4);
        chk("R2 hsk pin", {28'b0, hsk_req_n}, 32'hF);
        rd_chk("R2 unmapped addr", 12'h100, 32'h0);
        wr(12'h0EC, 32'h0);
        // R6: mapping gate
        cur_req = "R6";
        wr(12'h0F8, 32'h1);
        repeat (20) @(negedge clk);
        chk("R6 switch stays off", {31'b0, pwr_sw_on[0]}, 32'h0);
        rd_chk("R6 request pending", 12'h0F8, 32'h1);
        // R3: write zero does not clear
        cur_req = "R3";
        wr(12'h0F8, 32'h0);
        rd_chk("R3 request still set", 12'h0F8, 32'h1);
        // R4: power up domain 0
        cur_req = "R4";
        wr(12'h0EC, 32'h1);
        poll_clear("R4", 12'h0F8, 0);
        rd_chk("R4 status on", ctl(0) + 12'h00C, 32'h0);
        chk("R4 iso removed", {31'b0, iso_on[0]}, 32'h0);
        // R7: enable gate on power down
        cur_req = "R7";
        wr(12'h104, 32'h1);
        repeat (20) @(negedge clk);
        chk("R7 still on", {31'b0, pwr_sw_on[0]}, 32'h1);
        rd_chk("R7 pending", 12'h104, 32'h1);
        cur_req = "R5";
        wr(ctl(0), 32'h1);
        poll_clear("R5", 12'h104, 0);
        rd_chk("R5 status off", ctl(0) + 12'h00C, 32'h1);
        chk("R5 switch open", {31'b0, pwr_sw_on[0]}, 32'h0);
        // R8: both pending, up wins
        cur_req = "R8";
        wr(12'h0EC, 32'h0);
        wr(12'h104, 32'h2);
        wr(12'h0F8, 32'h2);
        wr(12'h0EC, 32'h2);
        poll_clear("R8", 12'h0F8, 1);
        rd_chk("R8 down dropped", 12'h104, 32'h0);
        chk("R8 domain on", {31'b0, pwr_sw_on[1]}, 32'h1);
        // R9: handshake domain 2
        cur_req = "R9";
        wr(12'h0EC, 32'h4);
        wr(12'h0F8, 32'h4);
        poll_clear("R9 up", 12'h0F8, 2);
        wr(ctl(2), 32'h1);
        wr(12'h1FC, 32'h0);
        chk("R9 pin low", {31'b0, hsk_req_n[2]}, 32'h0);
        wr(12'h104, 32'h4);
        repeat (30) @(negedge clk);
        chk("R9 waits for ack", {31'b0, pwr_sw_on[2]}, 32'h1);
        rd_chk("R9 pending", 12'h104, 32'h4);
        hsk_ack_n[2] = 1'b0;
        poll_clear("R9 down", 12'h104, 2);
        chk("R9 switch open", {31'b0, pwr_sw_on[2]}, 32'h0);
        hsk_ack_n[2] = 1'b1;
        // R10: lowest index first
        cur_req = "R10";
        wr(12'h0EC, 32'h0);
        wr(12'h0F8, 32'h8);
        wr(12'h104, 32'h2);
        wr(12'h0EC, 32'hA);
        poll_clear("R10 d1 down", 12'h104, 1);
        rd_chk("R10 d3 still waiting", 12'h0F8, 32'h8);
        poll_clear("R10 d3 up", 12'h0F8, 3);
        chk("R10 final switches", {28'b0, pwr_sw_on}, 32'h8);
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule